// File: doc/BRIEF.md
# Shared Multi-Line Receive Silo

This block collects received characters from all lines of an eight-line serial multiplexer into one queue. Each line's receiver presents a character with a one-cycle strobe and its framing and parity error bits. The silo stores the character together with the number of the line it came from. Carrier-detect inputs from the modems are synchronised, and every change of level is queued in the same silo. A modem entry is marked by an error-bit combination that no character entry can carry. Software reads one 16-bit word at a time. The read returns the head entry and removes it, and a word with bit 15 clear means the silo is empty.

Each line has a one-entry holding stage in front of the shared queue. A fixed-priority arbiter moves at most one entry per cycle into the queue and always prefers the lowest line number. When the queue is full, the holding stages keep their entries. A line that receives another character while its stage is still occupied loses that character, and the loss is flagged on the next character stored for that line. A master reset preloads eight self-test result words, so software can verify the block right after reset. An interrupt request is raised while entries are waiting and the receive interrupt enable is set.

Top module: `mux_rx_silo`

## Requirements
- R1: With the silo empty, `rd_word` is all zeros. Bit 15 is the valid flag and is therefore clear.
- R2: A character entry reads as: bit 15 = 1, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number, bits 7:0 = character. The framing and parity bits are copied from the line's inputs.
- R3: Entries leave in the order they entered the silo. Each `rd_stb` pulse on a non-empty silo removes exactly the head entry.
- R4: Characters strobed on several lines in the same cycle enter the silo one per cycle, lowest line number first.
- R5: Each change of a line's carrier-detect level queues exactly one entry, after a two-flop synchroniser. The entry reads: bits 15:12 = 1111, bits 11:8 = line number, bit 4 = the new level, and all other bits 0.
- R6: Bit 12 of `stat_word` is the synchronised carrier-detect level of the line chosen by `stat_sel`. All other bits of `stat_word` are 0.
- R7: After reset, the silo holds eight entries for line 0 with no error flags. Their character bytes are, in read order: 0x01, 0x11, 0x21, 0x81, 0x41, 0x51, 0x83, 0x71. The bytes 0x81 and 0x83 are fillers. Every other code has bit 7 clear and bit 0 set.
- R8: A full silo accepts nothing, and each line's pending entry waits in its holding stage. A character that arrives while its line's stage is occupied is discarded. The next character stored for that line has bit 14 (overrun) set.
- R9: A character entry never has bits 14:12 all set. When overrun and framing error both apply, the parity bit is cleared.
- R10: `rx_irq` is high exactly when `rx_ie` is high and the silo is non-empty.
- R11: `rd_stb` on an empty silo has no effect. Entries stored later read back normally, and the silo then reads empty again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| rx_stb | input | N_LINES | Per-line character strobe, one cycle per character |
| rx_char | input | 8*N_LINES | Per-line received character, line k in bits 8k+7:8k |
| rx_fe | input | N_LINES | Per-line framing error, qualified by rx_stb |
| rx_pe | input | N_LINES | Per-line parity error, qualified by rx_stb |
| cd_async | input | N_LINES | Per-line carrier-detect level, asynchronous |
| rd_stb | input | 1 | Read pulse: pops the head entry |
| rd_word | output | 16 | Head entry with valid flag, or zero when empty |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive interrupt request |
| stat_sel | input | $clog2(N_LINES) | Line chosen for the status word |
| stat_word | output | 16 | Line status: bit 12 = carrier-detect level |

## Verification
The bench fills the silo to its limit and then strobes two more characters on one line. A design that overwrote the held entry, or forgot the lost character, would show the wrong byte or a clear overrun bit in the entry after it. The same character also carries framing and parity errors, which checks that a real character can never look like a modem entry. Three lines strobe in one cycle to catch an arbiter that drops or reorders simultaneous arrivals. Reads on an empty silo are followed by a normal store and read. A design whose pointers wrapped on underflow would return stale data there.

// File: rtl/mux_rx_silo_pkg.sv
package mux_rx_silo_pkg;

    localparam int LINE_W     = 4;
    localparam int CHAR_W     = 8;
    localparam int SELFTEST_N = 8;
    localparam int WORD_W     = 16;

    typedef struct packed {
        logic              ovr;
        logic              fe;
        logic              pe;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_entry_t;

    localparam int ENTRY_W = $bits(silo_entry_t);

    // Self-test byte for preload slot idx: fillers in slots 3 and 6.
    function automatic logic [CHAR_W-1:0] selftest_code(input int idx);
        logic [2:0] k;
        k = idx[2:0];
        case (k)
            3'd3:    return 8'h81;
            3'd6:    return 8'h83;
            default: return {1'b0, k, 4'b0001};
        endcase
    endfunction

    // Carrier-change marker: all three error flags set.
    function automatic silo_entry_t modem_entry(input logic [LINE_W-1:0] line,
                                                input logic lvl);
        silo_entry_t e;
        e.ovr  = 1'b1;
        e.fe   = 1'b1;
        e.pe   = 1'b1;
        e.line = line;
        e.ch   = {3'b000, lvl, 4'b0000};
        return e;
    endfunction

    // Character entry; parity is dropped when overrun and framing coincide.
    function automatic silo_entry_t char_entry(input logic [LINE_W-1:0] line,
                                               input logic [CHAR_W-1:0] ch,
                                               input logic fe,
                                               input logic pe,
                                               input logic ovr);
        silo_entry_t e;
        e.ovr  = ovr;
        e.fe   = fe;
        e.pe   = pe & ~(ovr & fe);
        e.line = line;
        e.ch   = ch;
        return e;
    endfunction

endpackage

// File: rtl/mux_rx_silo_lane.sv
module mux_rx_silo_lane
    import mux_rx_silo_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic [CHAR_W-1:0]   ch,
    input  logic                fe,
    input  logic                pe,
    input  logic                cd_async,
    input  logic                grant,
    output logic                req,
    output silo_entry_t         entry_out,
    output logic                cd_level
);

    localparam logic [LINE_W-1:0] LID = LINE_W'(LINE_ID);

    logic        cd_s1, cd_s2, cd_s3;
    logic        mdm_pend, mdm_lvl;
    logic        hold_v, miss;
    silo_entry_t hold_e;
    logic        hold_free;

    assign hold_free = !hold_v || (grant && !mdm_pend);
    assign req       = mdm_pend || hold_v;
    assign entry_out = mdm_pend ? modem_entry(LID, mdm_lvl) : hold_e;
    assign cd_level  = cd_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cd_s1    <= 1'b0;
            cd_s2    <= 1'b0;
            cd_s3    <= 1'b0;
            mdm_pend <= 1'b0;
            mdm_lvl  <= 1'b0;
            hold_v   <= 1'b0;
            hold_e   <= '0;
            miss     <= 1'b0;
        end else begin
            cd_s1 <= cd_async;
            cd_s2 <= cd_s1;
            cd_s3 <= cd_s2;
            if (grant) begin
                if (mdm_pend) mdm_pend <= 1'b0;
                else          hold_v   <= 1'b0;
            end
            if (cd_s2 != cd_s3) begin
                mdm_pend <= 1'b1;
                mdm_lvl  <= cd_s2;
            end
            if (stb) begin
                if (hold_free) begin
                    hold_v <= 1'b1;
                    hold_e <= char_entry(LID, ch, fe, pe, miss);
                    miss   <= 1'b0;
                end else begin
                    miss <= 1'b1;
                end
            end
        end
    end

    // R9: a character entry never looks like a modem marker
    a_r9_char_not_marker: assert property (@(posedge clk) disable iff (rst)
        (req && !mdm_pend) |-> !(entry_out.ovr && entry_out.fe && entry_out.pe));

    // R8: a held character is kept untouched until it is drained
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (hold_v && !(grant && !mdm_pend)) |=> (hold_v && $stable(hold_e)));

    // R5: a modem entry is only presented after a synchronised edge
    a_r5_marker_after_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(mdm_pend) |-> (mdm_lvl == cd_s3));

endmodule

// File: rtl/mux_rx_silo_arb.sv
module mux_rx_silo_arb #(
    parameter int N_REQ = 8,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic             enable,
    output logic [N_REQ-1:0] grant,
    output logic [IDX_W-1:0] gnt_idx
);

    always_comb begin
        grant   = '0;
        gnt_idx = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (enable && req[i] && (grant == '0)) begin
                grant[i] = 1'b1;
                gnt_idx  = IDX_W'(i);
            end
        end
    end

    // R4: at most one lane moves per cycle
    a_r4_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R8: nothing moves while the silo is full
    a_r8_no_grant_full: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (grant == '0));

    // R4: an active request is not passed over when the silo has room
    a_r4_no_idle_grant: assert property (@(posedge clk) disable iff (rst)
        (enable && (req != '0)) |-> (grant != '0));

endmodule

// File: rtl/mux_rx_silo_fifo.sv
module mux_rx_silo_fifo
    import mux_rx_silo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  silo_entry_t push_data,
    input  logic        pop,
    output silo_entry_t head,
    output logic        empty,
    output logic        full
);

    silo_entry_t       mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i < SELFTEST_N)
                    mem[i] <= char_entry('0, selftest_code(i), 1'b0, 1'b0, 1'b0);
                else
                    mem[i] <= '0;
            end
            wr_ptr <= AW'(SELFTEST_N);
            rd_ptr <= '0;
            count  <= CW'(SELFTEST_N);
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

    // R3: a lone pop removes exactly one entry
    a_r3_pop_one: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
    import mux_rx_silo_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DEPTH   = 16,
    localparam int SEL_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_LINES-1:0]        rx_stb,
    input  logic [N_LINES*CHAR_W-1:0] rx_char,
    input  logic [N_LINES-1:0]        rx_fe,
    input  logic [N_LINES-1:0]        rx_pe,
    input  logic [N_LINES-1:0]        cd_async,
    input  logic                      rd_stb,
    output logic [WORD_W-1:0]         rd_word,
    input  logic                      rx_ie,
    output logic                      rx_irq,
    input  logic [SEL_W-1:0]          stat_sel,
    output logic [WORD_W-1:0]         stat_word
);

    logic [N_LINES-1:0] lane_req, lane_gnt, lane_cd;
    silo_entry_t        lane_entry [N_LINES];
    logic [SEL_W-1:0]   gnt_idx;
    silo_entry_t        head;
    logic               empty, full, pop;

    for (genvar g = 0; g < N_LINES; g++) begin : g_lane
        mux_rx_silo_lane #(.LINE_ID(g)) i_lane (
            .clk       (clk),
            .rst       (rst),
            .stb       (rx_stb[g]),
            .ch        (rx_char[g*CHAR_W +: CHAR_W]),
            .fe        (rx_fe[g]),
            .pe        (rx_pe[g]),
            .cd_async  (cd_async[g]),
            .grant     (lane_gnt[g]),
            .req       (lane_req[g]),
            .entry_out (lane_entry[g]),
            .cd_level  (lane_cd[g])
        );
    end

    mux_rx_silo_arb #(.N_REQ(N_LINES)) i_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (lane_req),
        .enable  (!full),
        .grant   (lane_gnt),
        .gnt_idx (gnt_idx)
    );

    assign pop = rd_stb && !empty;

    mux_rx_silo_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (|lane_gnt),
        .push_data (lane_entry[gnt_idx]),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    assign rd_word   = empty ? '0 : {1'b1, head};
    assign rx_irq    = rx_ie && !empty;
    assign stat_word = {3'b000, lane_cd[stat_sel], 12'h000};

    // R10: a request implies a valid word is waiting
    a_r10_irq_has_data: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rd_word[15]);

    a_r10_irq_when_enabled: assert property (@(posedge clk) disable iff (rst)
        (rx_ie && rd_word[15]) |-> rx_irq);

    // R1: an invalid word carries no other bits
    a_r1_empty_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_word[15] |-> (rd_word == '0));

endmodule

// File: tb/test_mux_rx_silo.sv
module test_mux_rx_silo;

    localparam int N = 8;
    localparam int D = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  rx_stb = '0;
    logic [N*8-1:0] rx_char = '0;
    logic [N-1:0]  rx_fe = '0;
    logic [N-1:0]  rx_pe = '0;
    logic [N-1:0]  cd_async = '0;
    logic          rd_stb = 1'b0;
    logic [15:0]   rd_word;
    logic          rx_ie = 1'b0;
    logic          rx_irq;
    logic [2:0]    stat_sel = '0;
    logic [15:0]   stat_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mux_rx_silo #(.N_LINES(N), .DEPTH(D)) i_mux_rx_silo (
        .clk, .rst, .rx_stb, .rx_char, .rx_fe, .rx_pe, .cd_async,
        .rd_stb, .rd_word, .rx_ie, .rx_irq, .stat_sel, .stat_word
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cword(input int line, input logic [7:0] ch,
                                          input bit ovr, input bit fe, input bit pe);
        return 16'h8000 | (16'(ovr) << 14) | (16'(fe) << 13) | (16'(pe) << 12)
             | (16'(line) << 8) | 16'(ch);
    endfunction

    task automatic read_expect(input string tag, input logic [15:0] exp);
        @(negedge clk);
        check(tag, rd_word, exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic push_char(input int line, input logic [7:0] ch, input bit fe, input bit pe);
        @(negedge clk);
        rx_stb[line] = 1'b1;
        rx_char[line*8 +: 8] = ch;
        rx_fe[line] = fe;
        rx_pe[line] = pe;
        @(negedge clk);
        rx_stb = '0;
        rx_fe  = '0;
        rx_pe  = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_contents;
        logic [7:0] codes [8] = '{8'h01, 8'h11, 8'h21, 8'h81, 8'h41, 8'h51, 8'h83, 8'h71};
        @(negedge clk);
        check("R10 irq off when disabled", 16'(rx_irq), 16'h0);
        rx_ie = 1'b1;
        @(negedge clk);
        check("R10 irq on with data", 16'(rx_irq), 16'h1);
        for (int i = 0; i < 8; i++)
            read_expect("R7 self-test word", cword(0, codes[i], 0, 0, 0));
        read_expect("R1 empty after self-test", 16'h0000);
        check("R10 irq off when empty", 16'(rx_irq), 16'h0);
    endtask

    task automatic t_char_format;
        push_char(3, 8'h5A, 0, 0);
        push_char(0, 8'hC3, 1, 0);
        push_char(6, 8'h0F, 0, 1);
        push_char(1, 8'h99, 1, 1);
        read_expect("R2 plain char", cword(3, 8'h5A, 0, 0, 0));
        read_expect("R2 framing error", cword(0, 8'hC3, 0, 1, 0));
        read_expect("R3 order parity", cword(6, 8'h0F, 0, 0, 1));
        read_expect("R2 both errors", cword(1, 8'h99, 0, 1, 1));
        read_expect("R1 empty", 16'h0000);
    endtask

    task automatic t_simultaneous;
        @(negedge clk);
        rx_stb = 8'b1010_0100;
        rx_char[5*8 +: 8] = 8'h55;
        rx_char[2*8 +: 8] = 8'h22;
        rx_char[7*8 +: 8] = 8'h77;
        @(negedge clk);
        rx_stb = '0;
        repeat (6) @(negedge clk);
        read_expect("R4 lowest line first", cword(2, 8'h22, 0, 0, 0));
        read_expect("R4 middle line", cword(5, 8'h55, 0, 0, 0));
        read_expect("R4 highest line last", cword(7, 8'h77, 0, 0, 0));
        read_expect("R1 empty after burst", 16'h0000);
    endtask

    task automatic t_modem;
        @(negedge clk);
        cd_async[4] = 1'b1;
        repeat (8) @(negedge clk);
        stat_sel = 3'd4;
        @(negedge clk);
        check("R6 status carrier high", stat_word, 16'h1000);
        stat_sel = 3'd3;
        @(negedge clk);
        check("R6 other line low", stat_word, 16'h0000);
        read_expect("R5 rise entry", 16'hF410);
        read_expect("R5 one entry per edge", 16'h0000);
        cd_async[4] = 1'b0;
        repeat (8) @(negedge clk);
        stat_sel = 3'd4;
        @(negedge clk);
        check("R6 status carrier low", stat_word, 16'h0000);
        read_expect("R5 fall entry", 16'hF400);
        read_expect("R5 single fall entry", 16'h0000);
    endtask

    task automatic t_full_overrun;
        for (int i = 0; i < D; i++) push_char(1, 8'(i), 0, 0);
        push_char(1, 8'hA5, 0, 0);
        push_char(1, 8'hB6, 0, 0);
        for (int i = 0; i < D; i++)
            read_expect("R8 full silo contents", cword(1, 8'(i), 0, 0, 0));
        push_char(1, 8'hC7, 1, 1);
        read_expect("R8 held char survives", cword(1, 8'hA5, 0, 0, 0));
        read_expect("R9 overrun with framing clears parity", cword(1, 8'hC7, 1, 1, 0));
        read_expect("R8 dropped char absent", 16'h0000);
    endtask

    task automatic t_empty_pop;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_stb = 1'b1;
        end
        @(negedge clk);
        rd_stb = 1'b0;
        check("R11 still empty", rd_word, 16'h0000);
        push_char(6, 8'h3C, 0, 0);
        read_expect("R11 store after empty reads", cword(6, 8'h3C, 0, 0, 0));
        read_expect("R11 empty again", 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_contents();
        t_char_format();
        t_simultaneous();
        t_modem();
        t_full_overrun();
        t_empty_pop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule